// File: doc/BRIEF.md
# CAN Controller Operating-Mode Sequencer

This block is the operating-mode state machine of a CAN controller. Software posts mode requests (run, reset, forced reset, halt) as single-cycle pulses. The protocol engine reports what the node is doing: transmitting, receiving, a suspended transmission, bus idle, the end of a frame, a bus error, lost arbitration, bus-off, the end of bus-off recovery, and a bus stuck at the dominant level. From these inputs the sequencer decides the cycle in which the requested mode may take over. It reports the current mode, whether a request is still waiting, and a sticky flag for a stuck bus.

The block has three states: RUN (mode 00), RESET (mode 01) and HALT (mode 10). The transitions are:
- RUN to RESET, on a forced reset, or on a reset that is allowed to take effect now.
- RUN to HALT, on a granted halt request or on an automatic bus-off halt.
- RESET to HALT, on a halt request.
- HALT to RESET, on any reset request.
- RESET or HALT to RUN, on a run request seen together with bus idle.

A 2-bit recovery option sets what a halt means while the node is bus-off. A request is held in a one-deep pending register until it is granted. A newer request replaces it.

Top module: `can_mode_seq`

## Requirements
- R1: After reset the mode output is 01 (RESET), and `req_pending` and `lock_flag` are 0.
- R2: Request code 11 (forced reset) moves the mode to 01 on the clock edge after the request is registered, even while transmitting, receiving or bus-off.
- R3: Request code 01 (reset) takes effect at once while receiving, idle or bus-off. While transmitting it waits for `frame_end`.
- R4: Request code 10 (halt) from RUN waits for `frame_end` whenever `is_tx` or `is_rx` is high.
- R5: A `bus_err` or `arb_lost` pulse during a frame ends the wait of a pending reset or halt, just as `frame_end` does.
- R6: While `tx_suspended` is high, a reset request takes effect at `bus_idle`, at `frame_end`, or when `is_rx` rises. It takes effect at no other time.
- R7: With recovery option 00 during bus-off, a halt request is held until `bus_off` falls.
- R8: With recovery option 01, bus-off in RUN moves the mode to 10 one edge later, with no request needed.
- R9: With recovery option 10, bus-off in RUN moves the mode to 10 on the edge that samples `boff_rec_done`, with no request needed.
- R10: With recovery option 11, bus-off alone leaves the mode at RUN. A halt request made during bus-off is granted on the next edge.
- R11: While `bus_locked` is high, the mode never enters HALT. `lock_flag` is set while `bus_locked` is high, stays set afterwards, and clears only on entry to RESET. A reset request still takes effect.
- R12: From RESET or HALT, a run request (code 00) moves the mode to 00 only on an edge where `bus_idle` is high.
- R13: `req_pending` is 1 from the edge that registers a request until the edge on which the mode equals that request's target.
- R14: The mode output never takes the value 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | One-cycle strobe that posts a mode request |
| req_code | input | 2 | Request code: 00 run, 01 reset, 10 halt, 11 forced reset |
| bo_option | input | 2 | Bus-off recovery option, 00 to 11 |
| is_tx | input | 1 | Node is transmitting a frame |
| is_rx | input | 1 | Node is receiving a frame |
| tx_suspended | input | 1 | Transmission is in its suspend period |
| bus_idle | input | 1 | Bus is idle |
| frame_end | input | 1 | Current frame has completed |
| bus_err | input | 1 | Bus error detected |
| arb_lost | input | 1 | Arbitration lost |
| bus_off | input | 1 | Node is bus-off |
| boff_rec_done | input | 1 | Bus-off recovery finishes this cycle |
| bus_locked | input | 1 | Bus stuck at the dominant level |
| mode | output | 2 | Current mode: 00 run, 01 reset, 10 halt |
| req_pending | output | 1 | A request is waiting to be granted |
| lock_flag | output | 1 | Sticky stuck-bus flag |

## Verification
A request pulse is registered on its own edge. The earliest mode change is on the following edge, so an immediate grant shows on `mode` two edges after the strobe is driven. A status input that releases a waiting request (for example `frame_end`, `bus_idle`, `is_rx` or `boff_rec_done`) changes the mode on the edge that samples it, and so does a bus-off auto-halt. `req_pending` and `lock_flag` change on the same edge as the mode. The bench drives inputs just after the falling edge and samples every output at the falling edge. Its behavioural model advances on the same rising edge, so each expected value lines up with the edge on which it is due.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
    localparam int MODE_W = 2;
    localparam int CODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_RUN   = 2'b00,
        MODE_RESET = 2'b01,
        MODE_HALT  = 2'b10
    } mode_e;

    localparam logic [CODE_W-1:0] REQ_RUN   = 2'b00;
    localparam logic [CODE_W-1:0] REQ_RESET = 2'b01;
    localparam logic [CODE_W-1:0] REQ_HALT  = 2'b10;
    localparam logic [CODE_W-1:0] REQ_FORCE = 2'b11;

    localparam logic [1:0] BO_HOLD      = 2'b00;
    localparam logic [1:0] BO_AUTO_NOW  = 2'b01;
    localparam logic [1:0] BO_AUTO_DONE = 2'b10;
    localparam logic [1:0] BO_ON_REQ    = 2'b11;

    function automatic mode_e req_target(input logic [CODE_W-1:0] code);
        case (code)
            REQ_RUN:  req_target = MODE_RUN;
            REQ_HALT: req_target = MODE_HALT;
            default:  req_target = MODE_RESET;
        endcase
    endfunction
endpackage

// File: rtl/can_mode_req.sv
module can_mode_req
    import can_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CODE_W-1:0] req_code,
    input  mode_e             mode_d,
    output logic              pend_q,
    output logic [CODE_W-1:0] code_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            code_q <= REQ_RUN;
        end else if (req_valid) begin
            pend_q <= 1'b1;
            code_q <= req_code;
        end else if (pend_q && (req_target(code_q) == mode_d)) begin
            pend_q <= 1'b0;
        end
    end
endmodule

// File: rtl/can_mode_gate.sv
module can_mode_gate
    import can_mode_pkg::*;
(
    input  mode_e             mode_q,
    input  logic              pend_q,
    input  logic [CODE_W-1:0] code_q,
    input  logic [1:0]        bo_option,
    input  logic              is_tx,
    input  logic              is_rx,
    input  logic              tx_suspended,
    input  logic              bus_idle,
    input  logic              frame_end,
    input  logic              bus_err,
    input  logic              arb_lost,
    input  logic              bus_off,
    input  logic              boff_rec_done,
    input  logic              bus_locked,
    output logic              go_reset,
    output logic              go_halt,
    output logic              go_run
);
    logic frame_break;
    logic frame_ready;
    logic reset_ready;
    logic want_halt;
    logic boff_halt;

    always_comb begin
        frame_break = frame_end | bus_err | arb_lost;
        frame_ready = !(is_tx | is_rx) | frame_break;
        if (tx_suspended)
            reset_ready = bus_idle | frame_end | is_rx;
        else
            reset_ready = !is_tx | frame_break;

        want_halt = pend_q && (code_q == REQ_HALT);

        unique case (bo_option)
            BO_HOLD:      boff_halt = 1'b0;
            BO_AUTO_NOW:  boff_halt = 1'b1;
            BO_AUTO_DONE: boff_halt = boff_rec_done;
            BO_ON_REQ:    boff_halt = want_halt;
            default:      boff_halt = 1'b0;
        endcase

        go_reset = pend_q && ((code_q == REQ_FORCE) ||
                   ((code_q == REQ_RESET) &&
                    ((mode_q == MODE_HALT) || bus_off || reset_ready)));

        go_halt = 1'b0;
        if (!bus_locked) begin
            unique case (mode_q)
                MODE_RESET: go_halt = want_halt;
                MODE_RUN:   go_halt = bus_off ? boff_halt : (want_halt && frame_ready);
                default:    go_halt = 1'b0;
            endcase
        end

        go_run = pend_q && (code_q == REQ_RUN) && bus_idle && (mode_q != MODE_RUN);
    end
endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
    import can_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  go_reset,
    input  logic  go_halt,
    input  logic  go_run,
    input  logic  bus_locked,
    output mode_e mode_q,
    output mode_e mode_d,
    output logic  lock_q
);
    logic lock_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_RESET;
            lock_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
            lock_q <= lock_d;
        end
    end

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_RUN: begin
                if (go_reset)     mode_d = MODE_RESET;
                else if (go_halt) mode_d = MODE_HALT;
            end
            MODE_RESET: begin
                if (go_halt)      mode_d = MODE_HALT;
                else if (go_run)  mode_d = MODE_RUN;
            end
            MODE_HALT: begin
                if (go_reset)     mode_d = MODE_RESET;
                else if (go_run)  mode_d = MODE_RUN;
            end
            default:              mode_d = MODE_RESET;
        endcase
        lock_d = bus_locked |
                 (lock_q & !((mode_d == MODE_RESET) && (mode_q != MODE_RESET)));
    end
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
    import can_mode_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [1:0]  req_code,
    input  logic [1:0]  bo_option,
    input  logic        is_tx,
    input  logic        is_rx,
    input  logic        tx_suspended,
    input  logic        bus_idle,
    input  logic        frame_end,
    input  logic        bus_err,
    input  logic        arb_lost,
    input  logic        bus_off,
    input  logic        boff_rec_done,
    input  logic        bus_locked,
    output logic [1:0]  mode,
    output logic        req_pending,
    output logic        lock_flag
);
    mode_e             mode_q;
    mode_e             mode_d;
    logic              pend_q;
    logic [CODE_W-1:0] code_q;
    logic              go_reset;
    logic              go_halt;
    logic              go_run;
    logic              lock_q;

    can_mode_req u_req (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
        .mode_d(mode_d), .pend_q(pend_q), .code_q(code_q)
    );

    can_mode_gate u_gate (
        .mode_q(mode_q), .pend_q(pend_q), .code_q(code_q), .bo_option(bo_option),
        .is_tx(is_tx), .is_rx(is_rx), .tx_suspended(tx_suspended),
        .bus_idle(bus_idle), .frame_end(frame_end), .bus_err(bus_err),
        .arb_lost(arb_lost), .bus_off(bus_off), .boff_rec_done(boff_rec_done),
        .bus_locked(bus_locked), .go_reset(go_reset), .go_halt(go_halt),
        .go_run(go_run)
    );

    can_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .go_reset(go_reset), .go_halt(go_halt),
        .go_run(go_run), .bus_locked(bus_locked), .mode_q(mode_q),
        .mode_d(mode_d), .lock_q(lock_q)
    );

    always_comb begin
        mode        = mode_q;
        req_pending = pend_q;
        lock_flag   = lock_q;
    end
endmodule

// File: rtl/can_mode_seq_chk.sv
module can_mode_seq_chk
    import can_mode_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       pend_q,
    input logic [1:0] code_q,
    input logic [1:0] bo_option,
    input logic       bus_off,
    input logic       bus_idle,
    input logic       bus_locked,
    input logic       lock_flag
);
    assert_mode_legal_R14: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'b11);

    assert_force_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && code_q == REQ_FORCE) |=> (mode == MODE_RESET));

    assert_no_halt_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_HALT && bus_locked) |=> (mode != MODE_HALT));

    assert_lock_raised_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_locked |=> lock_flag);

    assert_run_on_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && $past(mode) != MODE_RUN) |-> $past(bus_idle));

    assert_auto_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && bus_off && bo_option == BO_AUTO_NOW && !bus_locked)
        |=> (mode != MODE_RUN));

    assert_hold_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && bus_off && bo_option == BO_HOLD && !(pend_q && code_q[0]))
        |=> (mode == MODE_RUN));
endmodule

bind can_mode_seq can_mode_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pend_q(pend_q), .code_q(code_q),
    .bo_option(bo_option), .bus_off(bus_off), .bus_idle(bus_idle),
    .bus_locked(bus_locked), .lock_flag(lock_flag)
);

// File: tb/can_mode_seq_test.sv
module can_mode_seq_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_code = 2'b00;
    logic [1:0] bo_option = 2'b00;
    logic is_tx = 0, is_rx = 0, tx_suspended = 0, bus_idle = 0, frame_end = 0;
    logic bus_err = 0, arb_lost = 0, bus_off = 0, boff_rec_done = 0, bus_locked = 0;
    logic [1:0] mode;
    logic req_pending, lock_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    can_mode_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
        .bo_option(bo_option), .is_tx(is_tx), .is_rx(is_rx),
        .tx_suspended(tx_suspended), .bus_idle(bus_idle), .frame_end(frame_end),
        .bus_err(bus_err), .arb_lost(arb_lost), .bus_off(bus_off),
        .boff_rec_done(boff_rec_done), .bus_locked(bus_locked), .mode(mode),
        .req_pending(req_pending), .lock_flag(lock_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference: 0 run, 1 reset, 2 halt
    int m_mode = 1;
    int m_pend = 0;
    int m_code = 0;
    int m_lock = 0;

    function automatic int tgt(int c);
        if (c == 0) return 0;
        if (c == 2) return 2;
        return 1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 1; m_pend = 0; m_code = 0; m_lock = 0;
        end else begin
            int nxt;
            bit busy_end;
            nxt = m_mode;
            busy_end = frame_end || bus_err || arb_lost;
            if (m_pend != 0 && m_code == 3 && m_mode != 1) nxt = 1;
            else if (m_pend != 0 && m_code == 1 && m_mode != 1) begin
                if (m_mode == 2 || bus_off) nxt = 1;
                else if (tx_suspended) begin
                    if (bus_idle || frame_end || is_rx) nxt = 1;
                end else if (!is_tx || busy_end) nxt = 1;
            end
            if (nxt == m_mode && !bus_locked) begin
                if (m_mode == 0) begin
                    if (bus_off) begin
                        if (bo_option == 1) nxt = 2;
                        else if (bo_option == 2 && boff_rec_done) nxt = 2;
                        else if (bo_option == 3 && m_pend != 0 && m_code == 2) nxt = 2;
                    end else if (m_pend != 0 && m_code == 2 &&
                                 ((!is_tx && !is_rx) || busy_end)) nxt = 2;
                end else if (m_mode == 1 && m_pend != 0 && m_code == 2) nxt = 2;
            end
            if (nxt == m_mode && m_mode != 0 && m_pend != 0 && m_code == 0 && bus_idle)
                nxt = 0;
            if (bus_locked) m_lock = 1;
            else if (nxt == 1 && m_mode != 1) m_lock = 0;
            if (req_valid) begin
                m_pend = 1; m_code = int'(req_code);
            end else if (m_pend != 0 && tgt(m_code) == nxt) m_pend = 0;
            m_mode = nxt;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (int'(mode) != m_mode || int'(req_pending) != m_pend ||
                int'(lock_flag) != m_lock) begin
                errors++;
                $display("FAIL R14 model: mode/pend/lock %0d/%0d/%0d expected %0d/%0d/%0d",
                         mode, req_pending, lock_flag, m_mode, m_pend, m_lock);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic req(input logic [1:0] c);
        req_valid = 1'b1; req_code = c;
        tick(1);
        req_valid = 1'b0;
    endtask

    task automatic go_oper();
        bus_idle = 1'b1;
        req(2'b00);
        tick(1);
        bus_idle = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(2);
        rst_n = 1'b1;
        tick(1);
        chk("R1 mode", int'(mode), 1);
        chk("R1 pending", int'(req_pending), 0);
        chk("R1 lock", int'(lock_flag), 0);

        // R12: run request waits for bus idle
        req(2'b00); tick(2);
        chk("R12 no idle", int'(mode), 1);
        chk("R13 pending held", int'(req_pending), 1);
        bus_idle = 1'b1; tick(1); bus_idle = 1'b0;
        chk("R12 idle run", int'(mode), 0);
        chk("R13 pending clear", int'(req_pending), 0);

        // R3: reset while transmitting waits for frame end
        is_tx = 1'b1; req(2'b01); tick(2);
        chk("R3 tx wait", int'(mode), 0);
        frame_end = 1'b1; tick(1); frame_end = 1'b0;
        chk("R3 tx frame end", int'(mode), 1);
        is_tx = 1'b0;

        // R3: reset while receiving is immediate
        go_oper(); is_rx = 1'b1; req(2'b01); tick(1);
        chk("R3 rx immediate", int'(mode), 1);
        is_rx = 1'b0;

        // R2: forced reset while transmitting
        go_oper(); is_tx = 1'b1; req(2'b11); tick(1);
        chk("R2 forced", int'(mode), 1);
        is_tx = 1'b0;

        // R4: halt while receiving waits
        go_oper(); is_rx = 1'b1; req(2'b10); tick(2);
        chk("R4 rx wait", int'(mode), 0);
        frame_end = 1'b1; tick(1); frame_end = 1'b0;
        chk("R4 rx halt", int'(mode), 2);
        is_rx = 1'b0;

        // R5: halt while transmitting ends on bus error
        go_oper(); is_tx = 1'b1; req(2'b10); tick(2);
        chk("R4 tx wait", int'(mode), 0);
        bus_err = 1'b1; tick(1); bus_err = 1'b0;
        chk("R5 bus error", int'(mode), 2);

        // R5: reset while transmitting ends on arbitration lost
        go_oper(); req(2'b01); tick(1);
        chk("R5 wait", int'(mode), 0);
        arb_lost = 1'b1; tick(1); arb_lost = 1'b0;
        chk("R5 arb lost", int'(mode), 1);
        is_tx = 1'b0;

        // R6: suspended transmission
        go_oper(); tx_suspended = 1'b1; req(2'b01); tick(2);
        chk("R6 suspended wait", int'(mode), 0);
        is_rx = 1'b1; tick(1); is_rx = 1'b0;
        chk("R6 becomes receiver", int'(mode), 1);
        go_oper(); req(2'b01); tick(1);
        chk("R6 wait again", int'(mode), 0);
        bus_idle = 1'b1; tick(1); bus_idle = 1'b0;
        chk("R6 bus idle", int'(mode), 1);
        tx_suspended = 1'b0;

        // R7: option 00
        go_oper(); bo_option = 2'b00; bus_off = 1'b1; req(2'b10); tick(2);
        chk("R7 held", int'(mode), 0);
        bus_off = 1'b0; tick(1);
        chk("R7 after recovery", int'(mode), 2);

        // R8: option 01
        go_oper(); bo_option = 2'b01; bus_off = 1'b1; tick(1);
        chk("R8 auto halt", int'(mode), 2);
        bus_off = 1'b0;

        // R9: option 10
        go_oper(); bo_option = 2'b10; bus_off = 1'b1; tick(3);
        chk("R9 wait recovery", int'(mode), 0);
        boff_rec_done = 1'b1; tick(1); boff_rec_done = 1'b0;
        chk("R9 halt at recovery", int'(mode), 2);
        bus_off = 1'b0;

        // R10: option 11
        go_oper(); bo_option = 2'b11; bus_off = 1'b1; tick(2);
        chk("R10 no auto", int'(mode), 0);
        req(2'b10); tick(1);
        chk("R10 request halt", int'(mode), 2);
        bus_off = 1'b0; bo_option = 2'b00;

        // R11: bus locked
        go_oper(); bus_locked = 1'b1; req(2'b10); tick(3);
        chk("R11 no halt", int'(mode), 0);
        chk("R11 lock flag", int'(lock_flag), 1);
        req(2'b01); tick(1);
        chk("R11 reset works", int'(mode), 1);
        bus_locked = 1'b0;
        go_oper();
        chk("R11 lock sticky", int'(lock_flag), 1);
        req(2'b01); tick(1);
        chk("R11 lock cleared", int'(lock_flag), 0);
        chk("R14 mode encoding", int'(mode), 1);

        tick(2);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule